// File: doc/BRIEF.md
# Multi-Target Serial Peripheral Programming Master

This block drives a shared SPI bus that reaches several peripheral chips. Each chip has its own active-low select line and its own limit on how many bytes one message may carry. Firmware issues a command that names a target and a byte count. It then supplies the bytes one at a time on a byte port. The block pulls that target's select low and moves the bits MSB-first in mode 0 (data changes while the clock is low, and is sampled as the clock rises). When the last byte is done, it releases the select. The bit rate comes from a programmable half-period divider. At a 200 MHz system clock the reset value of the divider gives 1 Mbit/s.

Targets 0 to 2 are fixed on-board chips and can only be written. Targets 3 to 6 sit on two option slots, with two selects per slot (target = 3 + 2*slot + line), and their received bytes are passed back. Each option slot also has two interrupt request lines. The block synchronizes these lines and holds them in sticky pending bits, so firmware can see that a slot device wants a read transfer and then issue one.

Top module: `spi_multi_master`

## Requirements
- R1: After reset, every select is high, `sclk` and `busy` are 0, `err_flag` is 0, no interrupt is pending, and `tx_take` and `rx_valid` are 0.
- R2: An accepted command pulls the select of its target low in the next cycle, with `busy` high, and no other select changes. If the divider half-period is H, the select returns high and `busy` falls exactly H cycles after the final falling clock edge. At most one select is ever low.
- R3: With half-period H, each bit holds `sclk` low for H cycles and then high for H cycles, so N bytes take 16*N*H cycles. Outside a select window `sclk` stays low.
- R4: `mosi` carries each byte MSB first and changes only on falling edges. `tx_take` pulses for one cycle each time a byte is taken from `tx_byte`: in the cycle after acceptance, and then in the cycle after each byte boundary except the last. Firmware must present the next byte before the following boundary.
- R5: `miso` is sampled on each rising edge. For targets 3 to 6, `rx_valid` pulses with the assembled byte (MSB first) in the cycle after each byte's last falling edge. For targets 0 to 2, `rx_valid` never pulses.
- R6: The byte limits are 21 for target 0, 5 for target 1, 4 for target 2, and 16 for targets 3 to 6. A command with a count of 0, a count above the target's limit, or a target index of 7 is rejected: `err_flag` rises in the next cycle and no select or clock moves. An accepted command clears `err_flag`.
- R7: A command presented while `busy` is high is ignored. It leaves the transfer and `err_flag` unchanged.
- R8: The half-period register resets to 100. A write of a nonzero value while idle takes effect from the next transfer. A write while busy, or a write of 0, is ignored.
- R9: An interrupt input that is high for one cycle sets its pending bit on the third rising clock edge after it is sampled high, and not before. The bit then stays set.
- R10: Writing 1 to an `irq_clr` bit clears that pending bit in the next cycle and leaves the other bits alone. If the synchronized input is still high, setting takes priority over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_tgt | input | 3 | Target index (0-2 fixed, 3-6 option slots) |
| cmd_count | input | 5 | Number of bytes in the transfer |
| tx_byte | input | 8 | Next byte to send |
| tx_take | output | 1 | Pulse: `tx_byte` has been taken |
| div_we | input | 1 | Write strobe for the half-period register |
| div_val | input | 16 | New half-period in system clocks |
| busy | output | 1 | A select window is open |
| err_flag | output | 1 | The last command was rejected |
| cs_n | output | 7 | Active-low selects, one per target |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rx_valid | output | 1 | Pulse: `rx_byte` holds a received byte |
| rx_byte | output | 8 | Received byte |
| irq_in | input | 4 | Option-slot interrupt lines (bit = 2*slot + line) |
| irq_clr | input | 4 | Write-one-to-clear for the pending bits |
| irq_pend | output | 4 | Sticky pending interrupt bits |

## Verification
The main function is tried in several ways:
- A single byte at the reset divider, which separates the divider's reset value from any value written later.
- A 21-byte burst at a short half-period, which covers the widest count and many back-to-back byte hand-offs.
- Option targets against fixed targets with a distinct slave byte pattern, which shows whether read-back is gated by target class and whether the bit order is correct.
- A command and a divider write injected in the middle of a transfer, which shows that neither leaks into the running frame or into the one after it.

The interrupt path is driven with single-cycle pulses to pin down its latency, with a held line to show that setting wins over clearing, and with two bits set at once to show that clearing is per bit.

// File: rtl/spi_mm_pkg.sv
`timescale 1ns/1ps
package spi_mm_pkg;
  localparam int NFIX        = 3;
  localparam int NSLOT       = 2;
  localparam int CS_PER_SLOT = 2;
  localparam int NTGT        = NFIX + NSLOT * CS_PER_SLOT;
  localparam int NIRQ        = NSLOT * 2;
  localparam int TGT_W       = $clog2(NTGT);
  localparam int CNT_W       = 5;
  localparam int DIV_W       = 16;
  localparam int BYTE_W      = 8;
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(100);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} eng_st_t;

  // Largest byte count each target accepts in one select window
  function automatic logic [CNT_W-1:0] max_bytes(input logic [TGT_W-1:0] t);
    case (t)
      TGT_W'(0): return CNT_W'(21);
      TGT_W'(1): return CNT_W'(5);
      TGT_W'(2): return CNT_W'(4);
      default:   return CNT_W'(16);
    endcase
  endfunction

  function automatic logic is_option(input logic [TGT_W-1:0] t);
    return t >= TGT_W'(NFIX);
  endfunction

  function automatic logic cmd_ok(input logic [TGT_W-1:0] t, input logic [CNT_W-1:0] n);
    return (t < TGT_W'(NTGT)) && (n != '0) && (n <= max_bytes(t));
  endfunction
endpackage

// File: rtl/spi_mm_cmd_gate.sv
`timescale 1ns/1ps
module spi_mm_cmd_gate
  import spi_mm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [TGT_W-1:0] cmd_tgt,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             busy,
  output logic             start,
  output logic             reject,
  output logic             start_opt,
  output logic             err_flag
);
  logic ok;
  assign ok        = cmd_ok(cmd_tgt, cmd_count);
  assign start     = cmd_valid && !busy && ok;
  assign reject    = cmd_valid && !busy && !ok;
  assign start_opt = is_option(cmd_tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_flag <= 1'b0;
    else if (reject) err_flag <= 1'b1;
    else if (start)  err_flag <= 1'b0;
  end
endmodule

// File: rtl/spi_mm_irq_latch.sv
`timescale 1ns/1ps
module spi_mm_irq_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] irq_clr,
  output logic [N-1:0] irq_pend
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1, s2, pend;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        pend <= 1'b0;
      end else begin
        s1   <= irq_in[i];
        s2   <= s1;
        pend <= s2 | (pend & ~irq_clr[i]);
      end
    end
    assign irq_pend[i] = pend;
  end
endmodule

// File: rtl/spi_mm_engine.sv
`timescale 1ns/1ps
module spi_mm_engine
  import spi_mm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TGT_W-1:0]  start_tgt,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic              start_opt,
  input  logic [DIV_W-1:0]  half,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              busy,
  output logic [TGT_W-1:0]  cur_tgt,
  output logic              cur_opt,
  output logic              sclk,
  output logic              mosi,
  output logic              tx_take,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam logic [CNT_W-1:0] ONE_B = CNT_W'(1);
  localparam logic [2:0]       LAST  = 3'(BYTE_W - 1);

  eng_st_t           st;
  logic [DIV_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh_tx, sh_rx;
  logic [2:0]        bit_i;
  logic [CNT_W-1:0]  left;
  logic              phase_end;

  assign phase_end = (cnt == half - DIV_W'(1));
  assign busy      = (st != ST_IDLE);
  assign mosi      = sh_tx[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sclk <= 1'b0;
      sh_tx <= '0; sh_rx <= '0; bit_i <= '0; left <= '0;
      cur_tgt <= '0; cur_opt <= 1'b0;
      tx_take <= 1'b0; rx_valid <= 1'b0; rx_byte <= '0;
    end else begin
      tx_take  <= 1'b0;
      rx_valid <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st <= ST_RUN; cnt <= '0; sclk <= 1'b0;
          sh_tx <= tx_byte; bit_i <= '0; left <= start_cnt;
          cur_tgt <= start_tgt; cur_opt <= start_opt; tx_take <= 1'b1;
        end
        ST_RUN: if (phase_end) begin
          cnt <= '0;
          if (!sclk) begin
            sclk  <= 1'b1;
            sh_rx <= {sh_rx[BYTE_W-2:0], miso};
          end else begin
            sclk  <= 1'b0;
            bit_i <= bit_i + 3'd1;
            if (bit_i == LAST) begin
              rx_valid <= cur_opt;
              rx_byte  <= sh_rx;
              if (left == ONE_B) st <= ST_TAIL;
              else begin
                left    <= left - ONE_B;
                sh_tx   <= tx_byte;
                tx_take <= 1'b1;
              end
            end else begin
              sh_tx <= {sh_tx[BYTE_W-2:0], 1'b0};
            end
          end
        end else cnt <= cnt + DIV_W'(1);
        ST_TAIL: if (phase_end) begin
          st <= ST_IDLE; cnt <= '0;
        end else cnt <= cnt + DIV_W'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_multi_master.sv
`timescale 1ns/1ps
module spi_multi_master
  import spi_mm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [TGT_W-1:0]  cmd_tgt,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              tx_take,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_val,
  output logic              busy,
  output logic              err_flag,
  output logic [NTGT-1:0]   cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  input  logic [NIRQ-1:0]   irq_in,
  input  logic [NIRQ-1:0]   irq_clr,
  output logic [NIRQ-1:0]   irq_pend
);
  // Named internal events, visible to the bound checker
  logic             start_evt, reject_evt, start_opt, cur_opt;
  logic [TGT_W-1:0] cur_tgt;
  logic [DIV_W-1:0] half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= DIV_RST;
    else if (div_we && !busy && (div_val != '0)) half_q <= div_val;
  end

  spi_mm_cmd_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_tgt(cmd_tgt),
    .cmd_count(cmd_count), .busy(busy), .start(start_evt), .reject(reject_evt),
    .start_opt(start_opt), .err_flag(err_flag)
  );

  spi_mm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .start_tgt(cmd_tgt),
    .start_cnt(cmd_count), .start_opt(start_opt), .half(half_q),
    .tx_byte(tx_byte), .miso(miso), .busy(busy), .cur_tgt(cur_tgt),
    .cur_opt(cur_opt), .sclk(sclk), .mosi(mosi), .tx_take(tx_take),
    .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  for (genvar i = 0; i < NTGT; i++) begin : g_sel
    assign cs_n[i] = !(busy && (cur_tgt == TGT_W'(i)));
  end

  spi_mm_irq_latch #(.N(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_clr(irq_clr), .irq_pend(irq_pend)
  );
endmodule

// File: rtl/spi_mm_checker.sv
`timescale 1ns/1ps
module spi_mm_checker
  import spi_mm_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NTGT-1:0] cs_n,
  input logic            sclk,
  input logic            busy,
  input logic            cmd_valid,
  input logic            start_evt,
  input logic            reject_evt,
  input logic            err_flag,
  input logic            rx_valid,
  input logic            cur_opt,
  input logic [NIRQ-1:0] irq_pend,
  input logic [NIRQ-1:0] irq_clr
);
  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));
  assert_start_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && !(&cs_n)));
  assert_clock_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !(&cs_n));
  assert_readback_option_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> cur_opt);
  assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (err_flag && (&cs_n) && !sclk));
  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> $stable(err_flag));
  assert_sticky_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_pend & $past(irq_pend & ~irq_clr)) == $past(irq_pend & ~irq_clr)));
endmodule

bind spi_multi_master spi_mm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .busy(busy),
  .cmd_valid(cmd_valid), .start_evt(start_evt), .reject_evt(reject_evt),
  .err_flag(err_flag), .rx_valid(rx_valid), .cur_opt(cur_opt),
  .irq_pend(irq_pend), .irq_clr(irq_clr)
);

// File: tb/spi_multi_master_test.sv
`timescale 1ns/1ps
module spi_multi_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_tgt = '0;
  logic [4:0] cmd_count = '0;
  logic [7:0] tx_byte = '0;
  logic       tx_take;
  logic       div_we = 1'b0;
  logic [15:0] div_val = '0;
  logic       busy, err_flag, sclk, mosi, rx_valid;
  logic       miso = 1'b0;
  logic [6:0] cs_n;
  logic [7:0] rx_byte;
  logic [3:0] irq_in = '0, irq_clr = '0, irq_pend;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] txq [32];
  logic [7:0] sq  [32];

  always #2.5 clk = ~clk;

  spi_multi_master uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_tgt(cmd_tgt),
    .cmd_count(cmd_count), .tx_byte(tx_byte), .tx_take(tx_take),
    .div_we(div_we), .div_val(div_val), .busy(busy), .err_flag(err_flag),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .irq_in(irq_in), .irq_clr(irq_clr), .irq_pend(irq_pend)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 32; i++) begin
      txq[i] = 8'((i * 29 + seed * 7 + 60) ^ 90);
      sq[i]  = 8'((i * 53 + seed * 11 + 17) ^ 165);
    end
  endtask

  // Behavioural per-cycle reference of one transfer; poke_t injects a busy-time command
  task automatic xfer(input int tgt, input int n, input int h, input int poke_t);
    int T = 16 * n * h;
    bit opt = (tgt >= 3);
    int b_cs = 0, b_sclk = 0, b_mosi = 0, b_take = 0, b_rx = 0, tk = 0;
    logic [6:0] exp_cs;
    @(negedge clk);
    tx_byte = txq[0]; cmd_tgt = 3'(tgt); cmd_count = 5'(n); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int t = 0; t <= T + h; t++) begin
      exp_cs = (t < T + h) ? ~(7'd1 << tgt) : 7'h7f;
      if (cs_n !== exp_cs || busy !== (t < T + h)) b_cs++;
      if (sclk !== ((t < T) && ((t % (2 * h)) >= h))) b_sclk++;
      if (t < T) begin
        int k = t / (2 * h);
        if (mosi !== txq[k / 8][7 - (k % 8)]) b_mosi++;
      end
      if (tx_take !== ((t < T) && (t % (16 * h) == 0))) b_take++;
      if (opt && t >= 16 * h && t <= T && (t % (16 * h) == 0)) begin
        if (rx_valid !== 1'b1 || rx_byte !== sq[t / (16 * h) - 1]) b_rx++;
      end else if (rx_valid !== 1'b0) b_rx++;
      if (tx_take) begin
        tk++;
        tx_byte = (tk < n) ? txq[tk] : 8'h00;
      end
      if (t < T) begin
        int k = t / (2 * h);
        miso = sq[k / 8][7 - (k % 8)];
      end else miso = 1'b0;
      if (t == poke_t) begin
        cmd_valid = 1'b1; cmd_tgt = 3'd1; cmd_count = 5'd0;
        div_we = 1'b1; div_val = 16'd7;
      end else begin
        cmd_valid = 1'b0; div_we = 1'b0;
      end
      @(negedge clk);
    end
    chk(b_cs == 0, "R2", "select/busy window mismatched cycles", b_cs, 0);
    chk(b_sclk == 0, "R3", "sclk mismatched cycles", b_sclk, 0);
    chk(b_mosi == 0, "R4", "mosi mismatched cycles", b_mosi, 0);
    chk(b_take == 0 && tk == n, "R4", "tx_take pattern errors / takes", b_take * 256 + tk, n);
    chk(b_rx == 0, "R5", "read-back mismatched cycles", b_rx, 0);
  endtask

  task automatic reject_cmd(input int tgt, input int n);
    int bad = 0;
    @(negedge clk);
    cmd_tgt = 3'(tgt); cmd_count = 5'(n); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(err_flag === 1'b1, "R6", "err_flag after bad command", err_flag, 1);
    for (int i = 0; i < 6; i++) begin
      if (cs_n !== 7'h7f || sclk !== 1'b0 || busy !== 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R6", "bus activity cycles after reject", bad, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n === 7'h7f, "R1", "cs_n", cs_n, 7'h7f);
    chk(sclk === 1'b0 && busy === 1'b0, "R1", "sclk/busy", {sclk, busy}, 0);
    chk(err_flag === 1'b0, "R1", "err_flag", err_flag, 0);
    chk(irq_pend === 4'h0, "R1", "irq_pend", irq_pend, 0);
    chk(tx_take === 1'b0 && rx_valid === 1'b0, "R1", "take/valid", {tx_take, rx_valid}, 0);

    // R8 reset divider value 100 -> 1 Mbit/s
    fill(1); xfer(1, 1, 100, -1);
    @(negedge clk); div_val = 16'd2; div_we = 1'b1;
    @(negedge clk); div_we = 1'b0;
    fill(2); xfer(0, 21, 2, -1);   // R6 largest count for target 0
    fill(3); xfer(3, 3, 2, -1);    // R5 option read-back
    fill(4); xfer(6, 2, 2, -1);
    fill(5); xfer(2, 4, 2, -1);    // R5 fixed target, no read-back

    // R6 rejections and clearing
    reject_cmd(1, 6);
    fill(6); xfer(4, 5, 2, -1);
    chk(err_flag === 1'b0, "R6", "err_flag cleared by accepted command", err_flag, 0);
    reject_cmd(3, 0);
    reject_cmd(0, 22);
    reject_cmd(7, 1);
    reject_cmd(2, 5);
    fill(7); xfer(5, 2, 2, -1);

    // R7 command and R8 divider write while busy are ignored
    fill(8); xfer(5, 2, 2, 10);
    chk(err_flag === 1'b0, "R7", "err_flag after busy-time command", err_flag, 0);
    fill(9); xfer(1, 2, 2, -1);
    @(negedge clk); div_val = 16'd0; div_we = 1'b1;
    @(negedge clk); div_we = 1'b0;
    fill(10); xfer(0, 1, 2, -1);   // R8 zero write ignored
    @(negedge clk); div_val = 16'd3; div_we = 1'b1;
    @(negedge clk); div_we = 1'b0;
    fill(11); xfer(3, 2, 3, -1);   // R8 new value applied

    // R9 synchronizer latency and stickiness
    irq_in = 4'b0100;
    @(negedge clk); irq_in = 4'b0000;
    chk(irq_pend === 4'h0, "R9", "pend after 1 edge", irq_pend, 0);
    @(negedge clk);
    chk(irq_pend === 4'h0, "R9", "pend after 2 edges", irq_pend, 0);
    @(negedge clk);
    chk(irq_pend === 4'b0100, "R9", "pend after 3 edges", irq_pend, 4'b0100);
    repeat (4) @(negedge clk);
    chk(irq_pend === 4'b0100, "R9", "pend held", irq_pend, 4'b0100);
    // R10 clear
    irq_clr = 4'b0100;
    @(negedge clk); irq_clr = 4'b0000;
    chk(irq_pend === 4'h0, "R10", "pend after clear", irq_pend, 0);
    // R10 set wins over clear while input held
    irq_in = 4'b0010;
    repeat (4) @(negedge clk);
    irq_clr = 4'b0010;
    @(negedge clk); irq_clr = 4'b0000;
    chk(irq_pend === 4'b0010, "R10", "held line survives clear", irq_pend, 4'b0010);
    irq_in = 4'b0000;
    repeat (3) @(negedge clk);
    irq_clr = 4'b0010;
    @(negedge clk); irq_clr = 4'b0000;
    chk(irq_pend === 4'h0, "R10", "clear after release", irq_pend, 0);
    // R10 per-bit clear
    irq_in = 4'b1001;
    @(negedge clk); irq_in = 4'b0000;
    repeat (3) @(negedge clk);
    chk(irq_pend === 4'b1001, "R9", "two lines pending", irq_pend, 4'b1001);
    irq_clr = 4'b0001;
    @(negedge clk); irq_clr = 4'b0000;
    chk(irq_pend === 4'b1000, "R10", "only bit 0 cleared", irq_pend, 4'b1000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule